// File: doc/BRIEF.md
# Four-Layer Road Track Linker

This block turns fired segment pixels from four detector layers into track records. Each layer supplies one bit per pixel position, meaning a segment was found there, and a two-bit slope class for each pixel. A road is a valid chain of one pixel per layer, fixed by a start phi index and a momentum bin. The road table is computed from parameters rather than stored.

Every road in the table stands for a track above the trigger's momentum threshold. The block checks each road and emits a record for every road it accepts. A record carries the momentum bin code, the phi index and a charge-sign bit.

An event begins with a start pulse. The pulse captures the layer inputs, and the block then walks the roads one per cycle. Phi runs in ascending order, and the bins run in ascending order within each phi. Accepted records leave through a valid/ready handshake. The number of records per event is capped. When a further match is found after the cap is reached, the scan stops and an overflow flag is raised. A one-cycle done pulse closes every event.

Top module: `road_linker`

## Requirements
- R1: After reset, `busy`, `trk_valid`, `evt_done` and `trk_ovf` are all 0.
- R2: Road (phi p, bin b) uses pixel (p + L*(1-b)) mod NPIX in layer L, for L = 0..3. Bin 0 steps +1 per layer, bin 1 stays put and bin 2 steps -1. A road matches only when its pixel is fired in all four layers, where layer L pixel q is bit `pix_in[L*NPIX+q]`.
- R3: With `all_layers`=0, the slope class is checked only on layers 2 and 3. The slope class of layer L pixel q is `slope_in[(L*NPIX+q)*2 +: 2]`. Bin 0 requires code 1 (low momentum, positive), bin 1 requires code 0 (high momentum) and bin 2 requires code 2 (low momentum, negative).
- R4: With `all_layers`=1, the same slope code is required on all four layers.
- R5: A record carries `trk_bin` = b and `trk_phi` = p. `trk_neg` is 1 exactly when b = 2.
- R6: Records of one event come out in ascending phi order, and in ascending bin order within the same phi.
- R7: At most MAX_TRK records are emitted per event. `trk_ovf` is set only when a match is found after MAX_TRK records have already gone out. An event with exactly MAX_TRK matches does not set it.
- R8: While `trk_valid` is 1 and `trk_ready` is 0, `trk_valid` stays 1 on the next cycle, and `trk_bin`, `trk_phi` and `trk_neg` keep their values.
- R9: `evt_done` is a one-cycle pulse that follows the last record. It never coincides with `trk_valid`. `trk_ovf` is valid with the pulse, and `busy` is 0 on the cycle after the pulse.
- R10: An `evt_start` seen while `busy` is 1 is ignored. The running event's records are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_start | input | 1 | Captures the layer inputs and starts a scan when idle |
| all_layers | input | 1 | 1: slope checked on all layers; 0: outer two only |
| pix_in | input | 4*NPIX | Fired pixels, layer L in bits L*NPIX upward |
| slope_in | input | 8*NPIX | Two-bit slope class for each pixel |
| busy | output | 1 | Event in progress |
| trk_valid | output | 1 | Record available |
| trk_ready | input | 1 | Sink accepts the record |
| trk_bin | output | 2 | Momentum bin code |
| trk_phi | output | PW | Phi index |
| trk_neg | output | 1 | Negative charge sign |
| evt_done | output | 1 | End-of-event pulse |
| trk_ovf | output | 1 | Record cap reached with matches remaining |

## Verification
The bench builds the block with NPIX=6 and MAX_TRK=5. That makes 18 roads and an event scan of about twenty cycles, so every road of every event is checked against a model of the road rule written out in the bench. With a cap of 5, both overflow and the exact-cap case are easy to reach. This is done with directed all-fired patterns and with events that have planted roads on a random background, in both slope modes. A randomly throttled ready covers the stall rule and the cap counting under back-pressure.

// File: rtl/road_link_pkg.sv
package road_link_pkg;
  localparam int NLAYER = 4;
  localparam int NBIN   = 3;

  typedef enum logic [1:0] {
    SL_HIGH   = 2'd0,
    SL_LOWPOS = 2'd1,
    SL_LOWNEG = 2'd2,
    SL_NONE   = 2'd3
  } slope_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } scan_state_e;

  // pixel used by road (phi, bin) in a layer; bin 0 leans +1 per layer, bin 2 leans -1
  function automatic int road_pixel(int phi, int bin, int layer, int npix);
    return (phi + npix + layer * (1 - bin)) % npix;
  endfunction

  // slope class a road of this bin demands
  function automatic logic [1:0] bin_slope(int bin);
    case (bin)
      0:       return SL_LOWPOS;
      1:       return SL_HIGH;
      default: return SL_LOWNEG;
    endcase
  endfunction

  function automatic logic layer_slope_checked(logic all_layers, int layer);
    return all_layers || (layer >= 2);
  endfunction
endpackage

// File: rtl/road_eval.sv
module road_eval
  import road_link_pkg::*;
#(
  parameter int NPIX = 12,
  parameter int PW   = $clog2(NPIX)
) (
  input  logic [NLAYER*NPIX-1:0]   pix,
  input  logic [2*NLAYER*NPIX-1:0] slp,
  input  logic                     all_layers,
  input  logic [PW-1:0]            phi,
  input  logic [1:0]               bin,
  output logic                     hit
);
  logic [NLAYER-1:0] layer_ok;

  for (genvar L = 0; L < NLAYER; L++) begin : g_layer
    always_comb begin : p_layer
      int q;
      q = road_pixel(int'(phi), int'(bin), L, NPIX);
      layer_ok[L] = pix[L*NPIX + q] &&
                    (!layer_slope_checked(all_layers, L) ||
                     (slp[(L*NPIX + q)*2 +: 2] == bin_slope(int'(bin))));
    end
  end

  assign hit = &layer_ok;
endmodule

// File: rtl/link_scan.sv
module link_scan
  import road_link_pkg::*;
#(
  parameter int NPIX    = 12,
  parameter int MAX_TRK = 288,
  parameter int PW      = $clog2(NPIX),
  parameter int CW      = $clog2(MAX_TRK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_start,
  input  logic          road_hit,
  input  logic          out_ready,
  output logic          load,
  output logic [PW-1:0] phi,
  output logic [1:0]    bin,
  output logic          busy,
  output logic          out_valid,
  output logic          done,
  output logic          ovf
);
  scan_state_e state;
  logic [CW-1:0] cnt;
  logic cap_full, emit, advance, last_road;

  assign load      = evt_start && (state == ST_IDLE);
  assign cap_full  = (cnt == CW'(MAX_TRK));
  assign emit      = (state == ST_SCAN) && road_hit && !cap_full;
  assign advance   = (state == ST_SCAN) && (!road_hit || (emit && out_ready));
  assign last_road = (phi == PW'(NPIX - 1)) && (bin == 2'(NBIN - 1));
  assign out_valid = emit;
  assign done      = (state == ST_DONE);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      phi   <= '0;
      bin   <= '0;
      cnt   <= '0;
      ovf   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (load) begin
          state <= ST_SCAN;
          phi   <= '0;
          bin   <= '0;
          cnt   <= '0;
          ovf   <= 1'b0;
        end
        ST_SCAN: begin
          if (road_hit && cap_full) begin
            ovf   <= 1'b1;
            state <= ST_DONE;
          end else if (advance) begin
            if (emit) cnt <= cnt + 1'b1;
            if (last_road) state <= ST_DONE;
            else if (bin == 2'(NBIN - 1)) begin
              bin <= '0;
              phi <= phi + 1'b1;
            end else bin <= bin + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/road_linker.sv
module road_linker
  import road_link_pkg::*;
#(
  parameter int NPIX    = 12,
  parameter int MAX_TRK = 288,
  localparam int PW     = $clog2(NPIX)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     evt_start,
  input  logic                     all_layers,
  input  logic [NLAYER*NPIX-1:0]   pix_in,
  input  logic [2*NLAYER*NPIX-1:0] slope_in,
  output logic                     busy,
  output logic                     trk_valid,
  input  logic                     trk_ready,
  output logic [1:0]               trk_bin,
  output logic [PW-1:0]            trk_phi,
  output logic                     trk_neg,
  output logic                     evt_done,
  output logic                     trk_ovf
);
  logic [NLAYER*NPIX-1:0]   pix_q;
  logic [2*NLAYER*NPIX-1:0] slp_q;
  logic                     all_q;
  logic                     load;
  logic                     scan_hit;
  logic [PW-1:0]            scan_phi;
  logic [1:0]               scan_bin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_q <= '0;
      slp_q <= '0;
      all_q <= 1'b0;
    end else if (load) begin
      pix_q <= pix_in;
      slp_q <= slope_in;
      all_q <= all_layers;
    end
  end

  road_eval #(.NPIX(NPIX), .PW(PW)) u_eval (
    .pix(pix_q), .slp(slp_q), .all_layers(all_q),
    .phi(scan_phi), .bin(scan_bin), .hit(scan_hit)
  );

  link_scan #(.NPIX(NPIX), .MAX_TRK(MAX_TRK), .PW(PW)) u_scan (
    .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .road_hit(scan_hit),
    .out_ready(trk_ready), .load(load), .phi(scan_phi), .bin(scan_bin),
    .busy(busy), .out_valid(trk_valid), .done(evt_done), .ovf(trk_ovf)
  );

  assign trk_phi = scan_phi;
  assign trk_bin = scan_bin;
  assign trk_neg = (scan_bin == 2'd2);
endmodule

// File: rtl/road_linker_chk.sv
module road_linker_chk #(
  parameter int NPIX    = 12,
  parameter int MAX_TRK = 288,
  parameter int PW      = $clog2(NPIX)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          evt_start,
  input logic          busy,
  input logic          trk_valid,
  input logic          trk_ready,
  input logic [1:0]    trk_bin,
  input logic [PW-1:0] trk_phi,
  input logic          trk_neg,
  input logic          evt_done,
  input logic          trk_ovf
);
  logic [15:0] acc_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_cnt <= '0;
    else if (evt_start && !busy) acc_cnt <= '0;
    else if (trk_valid && trk_ready) acc_cnt <= acc_cnt + 1'b1;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !busy && !trk_valid && !evt_done && !trk_ovf);

  a_r5_sign_from_bin: assert property (@(posedge clk) disable iff (!rst_n)
    trk_valid |-> (trk_neg == (trk_bin == 2'd2)) && (trk_bin != 2'd3));

  a_r7_cap_respected: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_valid && trk_ready) |-> (acc_cnt < 16'(MAX_TRK)));

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_valid && !trk_ready) |=> trk_valid && $stable(trk_bin) && $stable(trk_phi) && $stable(trk_neg));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> !evt_done && !busy);

  a_r9_done_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> !trk_valid);

  a_r10_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !evt_done) |=> busy);
endmodule

bind road_linker road_linker_chk #(.NPIX(NPIX), .MAX_TRK(MAX_TRK)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .busy(busy),
  .trk_valid(trk_valid), .trk_ready(trk_ready), .trk_bin(trk_bin),
  .trk_phi(trk_phi), .trk_neg(trk_neg), .evt_done(evt_done), .trk_ovf(trk_ovf)
);

// File: tb/sim_road_linker.sv
module sim_road_linker;
  localparam int CLK_PERIOD = 10;
  localparam int NPIX = 6;
  localparam int MAXT = 5;
  localparam int PW   = $clog2(NPIX);

  logic clk = 1'b0, rst_n = 1'b0, evt_start = 1'b0, all_layers = 1'b0, trk_ready = 1'b0;
  logic [4*NPIX-1:0] pix_in = '0;
  logic [8*NPIX-1:0] slope_in = '0;
  logic busy, trk_valid, trk_neg, evt_done, trk_ovf;
  logic [1:0] trk_bin;
  logic [PW-1:0] trk_phi;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int unsigned lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  road_linker #(.NPIX(NPIX), .MAX_TRK(MAXT)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .all_layers(all_layers),
    .pix_in(pix_in), .slope_in(slope_in), .busy(busy), .trk_valid(trk_valid),
    .trk_ready(trk_ready), .trk_bin(trk_bin), .trk_phi(trk_phi), .trk_neg(trk_neg),
    .evt_done(evt_done), .trk_ovf(trk_ovf)
  );

  function automatic int unsigned rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg >> 8;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench restatement of the road rule: walk layer by layer with a lean
  function automatic bit road_ok(logic [4*NPIX-1:0] px, logic [8*NPIX-1:0] sl,
                                 bit mode, int p, int b);
    int lean, q, want;
    lean = (b == 0) ? 1 : ((b == 1) ? 0 : -1);
    want = (b == 1) ? 0 : ((b == 0) ? 1 : 2);
    q = p;
    for (int L = 0; L < 4; L++) begin
      if (!px[L*NPIX + q]) return 0;
      if ((mode || L > 1) && (int'(sl[(L*NPIX+q)*2 +: 2]) != want)) return 0;
      q = q + lean;
      if (q >= NPIX) q -= NPIX;
      if (q < 0) q += NPIX;
    end
    return 1;
  endfunction

  task automatic run_event(logic [4*NPIX-1:0] px, logic [8*NPIX-1:0] sl, bit mode,
                           int ready_pct, int inject_at);
    int ep[3*NPIX], eb[3*NPIX];
    int nexp, got, cyc;
    bit pv, pr;
    int pbin, pphi, pneg;
    nexp = 0;
    for (int p = 0; p < NPIX; p++)
      for (int b = 0; b < 3; b++)
        if (road_ok(px, sl, mode, p, b)) begin ep[nexp] = p; eb[nexp] = b; nexp++; end
    @(negedge clk);
    while (busy) @(negedge clk);
    evt_start = 1'b1; pix_in = px; slope_in = sl; all_layers = mode;
    @(negedge clk);
    evt_start = 1'b0; pix_in = ~px; slope_in = ~sl; all_layers = ~mode;
    got = 0; cyc = 0; pv = 0; pr = 0; pbin = 0; pphi = 0; pneg = 0;
    forever begin
      trk_ready = (int'(rnd() % 100) < ready_pct);
      evt_start = (cyc == inject_at);
      #1;
      if (pv && !pr) begin
        check(trk_valid == 1'b1, "R8 valid held", trk_valid, 1);
        check(int'(trk_phi) == pphi && int'(trk_bin) == pbin && int'(trk_neg) == pneg,
              "R8 record held", int'(trk_phi)*4 + int'(trk_bin), pphi*4 + pbin);
      end
      if (evt_done) break;
      if (trk_valid && trk_ready) begin
        if (got < nexp) begin
          check(int'(trk_phi) == ep[got], "R2 R6 phi", int'(trk_phi), ep[got]);
          check(int'(trk_bin) == eb[got], "R3 R4 R5 bin", int'(trk_bin), eb[got]);
          check(int'(trk_neg) == int'(eb[got] == 2), "R5 sign", int'(trk_neg), int'(eb[got] == 2));
        end
        got++;
      end
      pv = trk_valid; pr = trk_ready;
      pbin = int'(trk_bin); pphi = int'(trk_phi); pneg = int'(trk_neg);
      cyc++;
      @(negedge clk);
    end
    evt_start = 1'b0;
    check(trk_valid == 1'b0, "R9 no valid with done", trk_valid, 0);
    check(got == ((nexp > MAXT) ? MAXT : nexp), "R7 record count", got,
          (nexp > MAXT) ? MAXT : nexp);
    check(int'(trk_ovf) == int'(nexp > MAXT), "R7 overflow", int'(trk_ovf), int'(nexp > MAXT));
    @(negedge clk); #1;
    check(evt_done == 1'b0 && busy == 1'b0, "R9 done pulse single", int'(evt_done) + int'(busy), 0);
  endtask

  // all pixels fired, inner layers one slope, outer layers another
  function automatic logic [8*NPIX-1:0] slopes_io(logic [1:0] inner, logic [1:0] outer);
    logic [8*NPIX-1:0] s;
    for (int i = 0; i < 4*NPIX; i++) s[i*2 +: 2] = (i < 2*NPIX) ? inner : outer;
    return s;
  endfunction

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [4*NPIX-1:0] px;
    logic [8*NPIX-1:0] sl;
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !trk_valid && !evt_done && !trk_ovf, "R1 reset state",
          int'(busy) + int'(trk_valid) + int'(evt_done) + int'(trk_ovf), 0);
    rst_n = 1'b1;
    // R3: all high slope, straight roads on every phi: 6 > 5 -> overflow
    run_event('1, slopes_io(2'd0, 2'd0), 1'b0, 100, -1);
    // R3 vs R4: inner slope ignored in baseline, required in all-layer mode
    run_event('1, slopes_io(2'd0, 2'd1), 1'b0, 70, -1);
    run_event('1, slopes_io(2'd0, 2'd1), 1'b1, 70, -1);
    run_event('1, slopes_io(2'd2, 2'd2), 1'b1, 50, -1);
    // R7: exactly five straight roads, no overflow
    px = '1;
    for (int L = 0; L < 4; L++) px[L*NPIX + 3] = 1'b0;
    run_event(px, slopes_io(2'd0, 2'd0), 1'b0, 60, -1);
    // R2: one layer empty -> nothing
    px = '1; px[2*NPIX +: NPIX] = '0;
    run_event(px, slopes_io(2'd0, 2'd0), 1'b0, 100, -1);
    // R10: start during the scan is ignored
    run_event('1, slopes_io(2'd1, 2'd1), 1'b1, 40, 3);
    // sweep: planted roads on random background, both modes, throttled ready
    for (int e = 0; e < 120; e++) begin
      px = '0; sl = '0;
      for (int i = 0; i < 4*NPIX; i++) begin
        px[i] = (rnd() % 3) != 0;
        sl[i*2 +: 2] = 2'(rnd() % 4);
      end
      for (int k = 0; k < int'(rnd() % 5); k++) begin
        int p, b, q;
        p = int'(rnd() % NPIX); b = int'(rnd() % 3); q = p;
        for (int L = 0; L < 4; L++) begin
          px[L*NPIX + q] = 1'b1;
          sl[(L*NPIX + q)*2 +: 2] = (b == 1) ? 2'd0 : ((b == 0) ? 2'd1 : 2'd2);
          q = (q + NPIX + 1 - b) % NPIX;
        end
      end
      run_event(px, sl, e[0], 30 + (e % 4) * 20, (e % 7 == 0) ? 2 : -1);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule